// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table and Dispatcher

This block keeps, for one function, a table of interrupt vectors and a bitmap of pending vectors inside a 4 KB register window. It turns interrupt requests from the device into message writes, each made of a 64-bit address and a 32-bit data word. Software programs each vector's address, data and mask through a 32-bit register port. The capability register logic supplies the global enable, the function-wide mask and a rescan strobe.

When a request arrives for a vector that is masked, or while the function is masked or disabled, the block records a pending bit instead of sending a message. A pending vector is released later in one of two ways: by a table write that leaves its entry unmasked, or by a rescan strobe that sweeps the whole table. Messages leave one at a time on a valid/ready interface. Vectors that are waiting together leave in ascending index order.

Top module: `msix_ctrl`

## Requirements
- R1: After reset every table word and every pending bit reads as zero, and `msg_valid_o` is low.
- R2: A register write at byte offset v*16 + 4*w stores the word. Here v is a vector below `NUM_VEC`, and w selects 0 = address low, 1 = address high, 2 = data, 3 = vector control. A read at that offset returns the stored word. Offsets below 0x800 that belong to no implemented vector read zero, and writes to them are dropped.
- R3: Writes at offsets 0x800 and above change nothing. A read at 0x800 + 4k returns pending bits 32k+31 down to 32k, with vector i at bit i mod 32. This matches vector i at bit i mod 8 of byte 0x800 + i/8.
- R4: A request for vector v, when v is unmasked and the function is enabled and unmasked, produces one message. Its address is {address high, address low with bits 1:0 cleared} and its data is the entry's data word.
- R5: Only a low-to-high transition of a request line acts. Holding the line high, or dropping it, sends nothing further.
- R6: A request made while vector control bit 0 is set, or while `func_mask_i` is high, or while `msix_en_i` is low, sets the vector's pending bit and sends no message.
- R7: One cycle after any write into vector v's entry, v is checked. If v is pending, its mask bit is clear, and the function is enabled and unmasked, its message is sent and its pending bit is cleared.
- R8: A `rescan_i` pulse, while the function is enabled and unmasked, releases every pending unmasked vector in ascending index order and clears its pending bit. Pending masked vectors stay pending.
- R9: While `msg_valid_o` is high and `msg_ready_i` is low, the message holds steady. Vectors waiting at the same time are sent lowest index first.
- R10: Request lines at indices `NUM_VEC` and above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte offset in the window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_i | input | IRQ_W | Per-vector request levels |
| msix_en_i | input | 1 | Global enable |
| func_mask_i | input | 1 | Function-wide mask |
| rescan_i | input | 1 | Pending-vector rescan strobe |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The assertions check, on every cycle, several rules. A message holds steady under backpressure and always has its low address bits clear. A message only starts when a vector was queued. A pending bit only rises after its request line was high. A masked or disabled request always leaves the vector pending. A rescan always clears every pending, unmasked vector. Only the directed scenarios can show the rest: the message contents derived from the table, that a held request line fires only once, the release triggered by a table write, the ascending order after a rescan, and that both pending-region writes and out-of-range request lines have no effect.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int WIN_AW = 12;

  typedef enum logic [1:0] {
    WD_ADDR_LO = 2'd0,
    WD_ADDR_HI = 2'd1,
    WD_DATA    = 2'd2,
    WD_CTRL    = 2'd3
  } entry_word_e;

  typedef struct packed {
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] data;
    logic [31:0] ctrl;
  } entry_t;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WIN_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [VEC_W-1:0]  sel_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_VEC-1:0] vmask_o,
  output entry_t            sel_entry_o,
  output logic              wr_hit_o,
  output logic [VEC_W-1:0]  wr_vec_o
);
  entry_t      tbl_q [NUM_VEC];
  logic        in_tbl;
  logic [VEC_W-1:0] vec;
  entry_word_e word;
  entry_t      rd_ent;
  logic        unused_lsb;

  assign unused_lsb = ^addr_i[1:0];
  assign in_tbl   = !addr_i[11] && (int'(addr_i[10:4]) < NUM_VEC);
  assign vec      = addr_i[4 +: VEC_W];
  assign word     = entry_word_e'(addr_i[3:2]);
  assign wr_hit_o = we_i && in_tbl;
  assign wr_vec_o = vec;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tbl_q[v] <= '0;
      end else if (wr_hit_o && vec == VEC_W'(v)) begin
        case (word)
          WD_ADDR_LO: tbl_q[v].addr_lo <= wdata_i;
          WD_ADDR_HI: tbl_q[v].addr_hi <= wdata_i;
          WD_DATA:    tbl_q[v].data    <= wdata_i;
          default:    tbl_q[v].ctrl    <= wdata_i;
        endcase
      end
    end
    assign vmask_o[v] = tbl_q[v].ctrl[0];
  end

  assign rd_ent      = tbl_q[vec];
  assign sel_entry_o = tbl_q[sel_i];

  always_comb begin
    rdata_o = '0;
    if (in_tbl) begin
      case (word)
        WD_ADDR_LO: rdata_o = rd_ent.addr_lo;
        WD_ADDR_HI: rdata_o = rd_ent.addr_hi;
        WD_DATA:    rdata_o = rd_ent.data;
        default:    rdata_o = rd_ent.ctrl;
      endcase
    end
  end
endmodule

// File: rtl/msix_pend_ctl.sv
module msix_pend_ctl #(
  parameter int NUM_VEC = 16,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] irq_i,
  input  logic               en_i,
  input  logic               fmask_i,
  input  logic               rescan_i,
  input  logic [NUM_VEC-1:0] vmask_i,
  input  logic               chk_vld_i,
  input  logic [VEC_W-1:0]   chk_vec_i,
  input  logic [NUM_VEC-1:0] take_i,
  output logic [NUM_VEC-1:0] pend_o,
  output logic [NUM_VEC-1:0] fire_o
);
  logic [NUM_VEC-1:0] irq_q, pend_q, fire_q;
  logic [NUM_VEC-1:0] edge_v, go, hold, chk_sel, release_v;
  logic               chk_vld_q;
  logic [VEC_W-1:0]   chk_vec_q;
  logic               deliver_ok;

  assign deliver_ok = en_i && !fmask_i;
  assign edge_v     = irq_i & ~irq_q;
  assign go         = edge_v & ~vmask_i & {NUM_VEC{deliver_ok}};
  assign hold       = edge_v & ~go;

  always_comb begin
    chk_sel = '0;
    if (chk_vld_q) chk_sel[chk_vec_q] = 1'b1;
  end

  // release: post-write check of one vector, or rescan of all
  assign release_v = pend_q & ~vmask_i & {NUM_VEC{deliver_ok}} &
                     (chk_sel | {NUM_VEC{rescan_i}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= '0;
      pend_q    <= '0;
      fire_q    <= '0;
      chk_vld_q <= 1'b0;
      chk_vec_q <= '0;
    end else begin
      irq_q     <= irq_i;
      pend_q    <= (pend_q & ~release_v & ~go) | hold;
      fire_q    <= (fire_q & ~take_i) | go | release_v;
      chk_vld_q <= chk_vld_i;
      chk_vec_q <= chk_vec_i;
    end
  end

  assign pend_o = pend_q;
  assign fire_o = fire_q;
endmodule

// File: rtl/msix_msg_out.sv
module msix_msg_out
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] fire_i,
  input  entry_t             entry_i,
  input  logic               ready_i,
  output logic [VEC_W-1:0]   sel_o,
  output logic [NUM_VEC-1:0] take_o,
  output logic               valid_o,
  output msg_t               msg_o
);
  logic valid_q, any, slot_free;
  msg_t msg_q;

  assign any       = |fire_i;
  assign slot_free = !valid_q || ready_i;

  always_comb begin
    sel_o = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (fire_i[i]) sel_o = VEC_W'(i);
    end
  end

  always_comb begin
    take_o = '0;
    if (slot_free && any) take_o[sel_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else if (slot_free) begin
      valid_q <= any;
      if (any) begin
        msg_q.addr <= {entry_i.addr_hi, entry_i.addr_lo[31:2], 2'b00};
        msg_q.data <= entry_i.data;
      end
    end
  end

  assign valid_o = valid_q;
  assign msg_o   = msg_q;
endmodule

// File: rtl/msix_ctrl.sv
module msix_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int IRQ_W   = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [11:0]      reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic             msix_en_i,
  input  logic             func_mask_i,
  input  logic             rescan_i,
  output logic             msg_valid_o,
  input  logic             msg_ready_i,
  output logic [63:0]      msg_addr_o,
  output logic [31:0]      msg_data_o
);
  localparam int VEC_W      = $clog2(NUM_VEC);
  localparam int PEND_WORDS = (NUM_VEC + 31) / 32;

  logic [NUM_VEC-1:0] vmask, pend, fire, take;
  logic [VEC_W-1:0]   sel, wr_vec;
  logic               wr_hit;
  logic [31:0]        tbl_rdata;
  entry_t             sel_entry;
  msg_t               msg;
  logic [PEND_WORDS*32-1:0] pend_pad;
  logic [NUM_VEC-1:0] irq_lo;

  if (IRQ_W > NUM_VEC) begin : g_irq_trim
    logic unused_irq_hi;
    assign unused_irq_hi = ^irq_i[IRQ_W-1:NUM_VEC];
    assign irq_lo        = irq_i[NUM_VEC-1:0];
  end else begin : g_irq_pad
    assign irq_lo = NUM_VEC'(irq_i);
  end

  msix_vec_table #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .sel_i      (sel),
    .rdata_o    (tbl_rdata),
    .vmask_o    (vmask),
    .sel_entry_o(sel_entry),
    .wr_hit_o   (wr_hit),
    .wr_vec_o   (wr_vec)
  );

  msix_pend_ctl #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_lo),
    .en_i     (msix_en_i),
    .fmask_i  (func_mask_i),
    .rescan_i (rescan_i),
    .vmask_i  (vmask),
    .chk_vld_i(wr_hit),
    .chk_vec_i(wr_vec),
    .take_i   (take),
    .pend_o   (pend),
    .fire_o   (fire)
  );

  msix_msg_out #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .entry_i(sel_entry),
    .ready_i(msg_ready_i),
    .sel_o  (sel),
    .take_o (take),
    .valid_o(msg_valid_o),
    .msg_o  (msg)
  );

  assign msg_addr_o = msg.addr;
  assign msg_data_o = msg.data;

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_VEC-1:0] = pend;
  end

  // pending region is read-only; table module already drops its writes
  always_comb begin
    reg_rdata_o = tbl_rdata;
    if (reg_addr_i[11]) begin
      reg_rdata_o = '0;
      if (int'(reg_addr_i[10:2]) < PEND_WORDS)
        reg_rdata_o = pend_pad[int'(reg_addr_i[10:2])*32 +: 32];
    end
  end
endmodule

// File: rtl/msix_ctrl_chk.sv
module msix_ctrl_chk #(
  parameter int NUM_VEC = 16,
  parameter int IRQ_W   = 18
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [IRQ_W-1:0]   irq_i,
  input logic               msix_en_i,
  input logic               func_mask_i,
  input logic               rescan_i,
  input logic               msg_valid_o,
  input logic               msg_ready_i,
  input logic [63:0]        msg_addr_o,
  input logic [31:0]        msg_data_o,
  input logic [NUM_VEC-1:0] pend,
  input logic [NUM_VEC-1:0] vmask,
  input logic [NUM_VEC-1:0] fire
);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));

  a_r4_addr_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_addr_o[1:0] == 2'b00));

  a_r9_from_queue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(|fire));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    a_r6_masked_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(irq_i[v]) && (!msix_en_i || func_mask_i)) |=> pend[v]);

    a_r3_pend_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend[v]) |-> $past(irq_i[v]));

    a_r8_rescan_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rescan_i && msix_en_i && !func_mask_i && pend[v] && !vmask[v]) |=> !pend[v]);
  end
endmodule

bind msix_ctrl msix_ctrl_chk #(.NUM_VEC(NUM_VEC), .IRQ_W(IRQ_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .msix_en_i  (msix_en_i),
  .func_mask_i(func_mask_i),
  .rescan_i   (rescan_i),
  .msg_valid_o(msg_valid_o),
  .msg_ready_i(msg_ready_i),
  .msg_addr_o (msg_addr_o),
  .msg_data_o (msg_data_o),
  .pend       (pend),
  .vmask      (vmask),
  .fire       (fire)
);

// File: tb/tb_msix_ctrl.sv
`timescale 1ns/1ps
module tb_msix_ctrl;
  localparam int NUM_VEC = 16;
  localparam int IRQ_W   = 18;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             reg_we = 1'b0;
  logic [11:0]      reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [IRQ_W-1:0] irq = '0;
  logic             en = 1'b1;
  logic             fmask = 1'b0;
  logic             rescan = 1'b0;
  logic             msg_valid;
  logic             msg_ready = 1'b1;
  logic [63:0]      msg_addr;
  logic [31:0]      msg_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msix_ctrl #(.NUM_VEC(NUM_VEC), .IRQ_W(IRQ_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_i(irq),
    .msix_en_i(en), .func_mask_i(fmask), .rescan_i(rescan),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  function automatic logic [31:0] v_lo(int v);  return 32'hFEE0_0003 | (v << 4); endfunction
  function automatic logic [31:0] v_hi(int v);  return 32'h0000_0100 + v;        endfunction
  function automatic logic [31:0] v_dat(int v); return 32'h0000_4000 + v;        endfunction
  function automatic logic [96:0] v_msg(int v);
    return {1'b1, v_hi(v), v_lo(v) & 32'hFFFF_FFFC, v_dat(v)};
  endfunction

  task automatic check(input string req, input logic [96:0] act, input logic [96:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, 97'(reg_rdata), 97'(exp));
  endtask

  task automatic pulse(input logic [IRQ_W-1:0] m);
    @(negedge clk); irq = m;
    @(negedge clk); irq = '0;
  endtask

  task automatic strobe_rescan();
    @(negedge clk); rescan = 1'b1;
    @(negedge clk); rescan = 1'b0;
  endtask

  task automatic expect_msg(input string req, input int v);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (msg_valid) break;
    end
    check(req, {msg_valid, msg_addr, msg_data}, v_msg(v));
  endtask

  task automatic expect_none(input string req, input int cyc);
    logic seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    check(req, 97'(seen), 97'(0));
  endtask

  task automatic t_reset();
    check("R1 valid", 97'(msg_valid), 97'(0));
    reg_chk("R1 tbl", 12'h000, 32'h0);
    reg_chk("R1 ctrl", 12'h01C, 32'h0);
    reg_chk("R1 pend", 12'h800, 32'h0);
  endtask

  task automatic t_program();
    for (int v = 0; v < 4; v++) begin
      reg_wr(12'(v*16 + 0), v_lo(v));
      reg_wr(12'(v*16 + 4), v_hi(v));
      reg_wr(12'(v*16 + 8), v_dat(v));
      reg_wr(12'(v*16 + 12), 32'h0);
    end
    reg_chk("R2 lo", 12'h020, v_lo(2));
    reg_chk("R2 data", 12'h038, v_dat(3));
    reg_wr(12'h100, 32'hDEAD_BEEF);
    reg_chk("R2 unimpl", 12'h100, 32'h0);
    reg_chk("R2 unimpl hi", 12'h7F0, 32'h0);
  endtask

  task automatic t_basic();
    pulse(IRQ_W'(1) << 1);
    expect_msg("R4 msg v1", 1);
    expect_none("R4 single", 4);
    @(negedge clk); irq[2] = 1'b1;
    expect_msg("R5 rise v2", 2);
    expect_none("R5 held high", 6);
    @(negedge clk); irq[2] = 1'b0;
    expect_none("R5 fall", 4);
  endtask

  task automatic t_vec_mask();
    reg_wr(12'h02C, 32'h1);
    pulse(IRQ_W'(1) << 2);
    expect_none("R6 vmask none", 4);
    reg_chk("R6 pend v2", 12'h800, 32'h4);
    reg_wr(12'h02C, 32'h0);
    expect_msg("R7 unmask fires", 2);
    reg_chk("R7 pend clr", 12'h800, 32'h0);
  endtask

  task automatic t_func_mask();
    fmask = 1'b1;
    pulse((IRQ_W'(1) << 0) | (IRQ_W'(1) << 3));
    expect_none("R6 fmask none", 4);
    reg_chk("R6 pend 0,3", 12'h800, 32'h9);
    reg_wr(12'h800, 32'hFFFF_FFFF);
    reg_chk("R3 pend write ignored", 12'h800, 32'h9);
    reg_wr(12'h03C, 32'h1);
    @(negedge clk); fmask = 1'b0;
    expect_none("R8 no auto resend", 4);
    strobe_rescan();
    expect_msg("R8 rescan v0", 0);
    expect_none("R8 masked stays", 4);
    reg_chk("R8 pend v3 kept", 12'h800, 32'h8);
    reg_wr(12'h03C, 32'h0);
    expect_msg("R7 unmask v3", 3);
    reg_chk("R7 pend empty", 12'h800, 32'h0);
  endtask

  task automatic t_disable_order();
    @(negedge clk); en = 1'b0;
    pulse(IRQ_W'(1) << 2);
    pulse(IRQ_W'(1) << 1);
    expect_none("R6 disabled none", 4);
    reg_chk("R6 pend 1,2", 12'h800, 32'h6);
    @(negedge clk); en = 1'b1;
    strobe_rescan();
    expect_msg("R8 order first v1", 1);
    expect_msg("R8 order then v2", 2);
    reg_chk("R8 pend clr", 12'h800, 32'h0);
  endtask

  task automatic t_backpressure();
    logic [96:0] held;
    @(negedge clk); msg_ready = 1'b0;
    pulse((IRQ_W'(1) << 3) | (IRQ_W'(1) << 1));
    repeat (3) @(negedge clk);
    held = {msg_valid, msg_addr, msg_data};
    check("R9 lowest first", held, v_msg(1));
    repeat (3) @(negedge clk);
    check("R9 stable", {msg_valid, msg_addr, msg_data}, held);
    msg_ready = 1'b1;
    expect_msg("R9 next v3", 3);
    expect_none("R9 drained", 4);
  endtask

  task automatic t_out_of_range();
    pulse((IRQ_W'(1) << NUM_VEC) | (IRQ_W'(1) << (NUM_VEC + 1)));
    expect_none("R10 no msg", 5);
    reg_chk("R10 no pend", 12'h800, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_program();
    t_basic();
    t_vec_mask();
    t_func_mask();
    t_disable_order();
    t_backpressure();
    t_out_of_range();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule